// File: doc/BRIEF.md
# E3 Synchronization Status Message Receiver

This block recovers the four-bit timing quality code that an E3 G.832 sender spreads over consecutive frames. An upstream framer presents the maintenance-and-adaptation overhead byte of each frame together with a one-cycle strobe and a flag saying whether frame alignment is held. Each accepted byte carries one message bit in its least significant position and a two-bit index that says which message bit it is. The block places each bit, checks that the indices advance in a strict 0, 1, 2, 3 cycle, and produces a freshly assembled word at the end of each complete multiframe.

A persistence filter sits behind the assembler. The assembled word becomes the validated value only after the same word has arrived in a run of consecutive complete multiframes whose length is set by a configuration input, and a one-cycle pulse marks each change of the validated value. The remaining fields of the overhead byte (remote defect, remote error and payload type) are decoded and registered from every accepted byte.

Top module: `e3_ssm_rx`

## Requirements
- R1: On each accepted strobe (ma_valid high while in_frame high) the outputs update after that clock edge with rdi = ma_byte[7], rei = ma_byte[6] and payload_type = ma_byte[5:3].
- R2: A strobe while in_frame is low is ignored: rdi, rei, payload_type and ssm_raw keep their values and no sequence error is raised.
- R3: The index is ma_byte[2:1] and the message bit is ma_byte[0]; index 0 carries bit 3 (most significant) and index 3 carries bit 0. ssm_raw is loaded, one edge after the index-3 strobe, only when indices 0, 1, 2 were accepted in order immediately before it.
- R4: When an accepted index differs from the previous accepted index plus one (modulo 4), seq_err pulses for one cycle and the partial word is discarded; an index 0 always starts a new word.
- R5: While in_frame is low the assembly is cleared and the previous index is forgotten, so the first accepted strobe afterwards never raises seq_err; the persistence run is also cleared.
- R6: ssm_stable takes a completed word once that same word has completed in persist_cfg consecutive multiframes (persist_cfg of 0 acts as 1), counted from the first completion after a reset, a sequence error or a loss of alignment; the run count saturates at its maximum.
- R7: ssm_change pulses for exactly one cycle, one edge after ssm_raw, whenever ssm_stable takes a value different from its previous one, and ssm_stable changes at no other time.
- R8: A synchronous active-high reset clears all outputs and the persistence run.
- R9: After reset, a sequence that starts at an index other than 0 completes no word and its first strobe raises no seq_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ma_valid | input | 1 | One-cycle strobe per frame, overhead byte valid |
| in_frame | input | 1 | Frame alignment held |
| ma_byte | input | 8 | Maintenance-and-adaptation overhead byte |
| persist_cfg | input | 3 | Number of identical consecutive multiframes required |
| ssm_raw | output | 4 | Most recently assembled message word |
| ssm_stable | output | 4 | Validated message word |
| ssm_change | output | 1 | One-cycle pulse on change of ssm_stable |
| seq_err | output | 1 | One-cycle pulse on an out-of-order index |
| rdi | output | 1 | Remote defect bit of the last accepted byte |
| rei | output | 1 | Remote error bit of the last accepted byte |
| payload_type | output | 3 | Payload type field of the last accepted byte |

## Verification
The hardest situation to reach is a persistence run that is broken and restarted: a candidate word is two multiframes into its run when a sequence error or a loss of alignment arrives, and the count must start again from the next clean multiframe rather than resume. The stimulus builds such runs on purpose, inserting a skipped index and a one-cycle alignment drop in the middle of a partially assembled word, and then sends exactly the number of clean multiframes needed so that an off-by-one in the restart shows as a wrong validated value. Threshold values of 0, 1 and the saturating maximum are driven alongside back-to-back strobes with no idle cycles.

// File: rtl/e3_ssm_pkg.sv
package e3_ssm_pkg;
    localparam int SSM_W  = 4;
    localparam int IDX_W  = $clog2(SSM_W);
    localparam int PT_W   = 3;
    localparam int CNT_W  = 3;

    // Overhead byte, most significant bit first
    typedef struct packed {
        logic             rdi;
        logic             rei;
        logic [PT_W-1:0]  ptype;
        logic [IDX_W-1:0] idx;
        logic             sbit;
    } ma_byte_t;

    typedef struct packed {
        logic             rdi;
        logic             rei;
        logic [PT_W-1:0]  ptype;
    } ma_fields_t;

    function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] i);
        return i + 1'b1;
    endfunction

    function automatic ma_fields_t split_fields(input ma_byte_t b);
        ma_fields_t f;
        f.rdi   = b.rdi;
        f.rei   = b.rei;
        f.ptype = b.ptype;
        return f;
    endfunction
endpackage

// File: rtl/ssm_seq_tracker.sv
module ssm_seq_tracker
    import e3_ssm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             flush,
    input  logic [IDX_W-1:0] idx,
    input  logic             sbit,
    output logic [SSM_W-1:0] word,
    output logic             word_done,
    output logic             seq_err,
    output logic             run_clear
);
    localparam int RUN_W = IDX_W + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SSM_W - 1);

    logic             have_prev;
    logic [IDX_W-1:0] prev_idx;
    logic [RUN_W-1:0] run;
    logic [SSM_W-1:0] part;
    logic [SSM_W-1:0] part_set;
    logic             in_order;

    assign in_order = !have_prev || (idx == idx_next(prev_idx));

    always_comb begin
        part_set = part;
        for (int i = 0; i < SSM_W; i++) begin
            if (i == SSM_W - 1 - int'(idx)) part_set[i] = sbit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            prev_idx  <= '0;
            run       <= '0;
            part      <= '0;
            word      <= '0;
            word_done <= 1'b0;
            seq_err   <= 1'b0;
            run_clear <= 1'b0;
        end else begin
            word_done <= 1'b0;
            seq_err   <= 1'b0;
            run_clear <= 1'b0;
            if (flush) begin
                have_prev <= 1'b0;
                run       <= '0;
                part      <= '0;
                run_clear <= 1'b1;
            end else if (accept) begin
                have_prev <= 1'b1;
                prev_idx  <= idx;
                if (!in_order) begin
                    seq_err   <= 1'b1;
                    run_clear <= 1'b1;
                end
                if (idx == '0) begin
                    run  <= RUN_W'(1);
                    part <= {sbit, {(SSM_W-1){1'b0}}};
                end else if (in_order && run == {1'b0, idx}) begin
                    part <= part_set;
                    if (idx == LAST_IDX) begin
                        word      <= part_set;
                        word_done <= 1'b1;
                        run       <= '0;
                    end else begin
                        run <= {1'b0, idx} + 1'b1;
                    end
                end else begin
                    run <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/ssm_persist_filter.sv
module ssm_persist_filter
    import e3_ssm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic [SSM_W-1:0] word,
    input  logic             clear,
    input  logic [CNT_W-1:0] thresh,
    output logic [SSM_W-1:0] stable,
    output logic             change
);
    logic [SSM_W-1:0] cand;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] thr_eff;

    assign thr_eff = (thresh == '0) ? CNT_W'(1) : thresh;

    always_comb begin
        if (cnt != '0 && word == cand)
            cnt_nx = (cnt == {CNT_W{1'b1}}) ? cnt : cnt + 1'b1;
        else
            cnt_nx = CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand   <= '0;
            cnt    <= '0;
            stable <= '0;
            change <= 1'b0;
        end else begin
            change <= 1'b0;
            if (done) begin
                cand <= word;
                cnt  <= cnt_nx;
                if (cnt_nx >= thr_eff && word != stable) begin
                    stable <= word;
                    change <= 1'b1;
                end
            end else if (clear) begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/ma_field_latch.sv
module ma_field_latch
    import e3_ssm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  ma_byte_t   byte_in,
    output ma_fields_t fields
);
    always_ff @(posedge clk) begin
        if (rst)         fields <= '0;
        else if (accept) fields <= split_fields(byte_in);
    end
endmodule

// File: rtl/e3_ssm_rx.sv
module e3_ssm_rx
    import e3_ssm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ma_valid,
    input  logic             in_frame,
    input  logic [7:0]       ma_byte,
    input  logic [CNT_W-1:0] persist_cfg,
    output logic [SSM_W-1:0] ssm_raw,
    output logic [SSM_W-1:0] ssm_stable,
    output logic             ssm_change,
    output logic             seq_err,
    output logic             rdi,
    output logic             rei,
    output logic [PT_W-1:0]  payload_type
);
    ma_byte_t   mb;
    ma_fields_t fields;
    logic       accept;
    logic       word_done;
    logic       run_clear;

    assign mb     = ma_byte_t'(ma_byte);
    assign accept = ma_valid && in_frame;

    ssm_seq_tracker u_trk (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .flush     (!in_frame),
        .idx       (mb.idx),
        .sbit      (mb.sbit),
        .word      (ssm_raw),
        .word_done (word_done),
        .seq_err   (seq_err),
        .run_clear (run_clear)
    );

    ssm_persist_filter u_flt (
        .clk    (clk),
        .rst    (rst),
        .done   (word_done),
        .word   (ssm_raw),
        .clear  (run_clear),
        .thresh (persist_cfg),
        .stable (ssm_stable),
        .change (ssm_change)
    );

    ma_field_latch u_fld (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .byte_in (mb),
        .fields  (fields)
    );

    assign rdi          = fields.rdi;
    assign rei          = fields.rei;
    assign payload_type = fields.ptype;
endmodule

// File: rtl/e3_ssm_rx_chk.sv
module e3_ssm_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       ma_valid,
    input logic       in_frame,
    input logic [7:0] ma_byte,
    input logic [3:0] ssm_raw,
    input logic [3:0] ssm_stable,
    input logic       ssm_change,
    input logic       seq_err,
    input logic       rdi,
    input logic       rei,
    input logic [2:0] payload_type
);
    logic pv;
    always_ff @(posedge clk) begin
        if (rst) pv <= 1'b0;
        else     pv <= 1'b1;
    end

    assert_fields_load_R1: assert property (@(posedge clk) disable iff (rst || !pv)
        $past(ma_valid && in_frame) |-> {rdi, rei, payload_type} == $past(ma_byte[7:3]));

    assert_fields_hold_R2: assert property (@(posedge clk) disable iff (rst || !pv)
        !$past(ma_valid && in_frame) |-> $stable({rdi, rei, payload_type}));

    assert_raw_source_R3: assert property (@(posedge clk) disable iff (rst || !pv)
        (ssm_raw != $past(ssm_raw)) |-> $past(ma_valid && in_frame && ma_byte[2:1] == 2'd3));

    assert_err_cause_R4: assert property (@(posedge clk) disable iff (rst || !pv)
        seq_err |-> $past(ma_valid && in_frame));

    assert_flush_quiet_R5: assert property (@(posedge clk) disable iff (rst || !pv)
        $past(!in_frame) |-> (!seq_err && $stable(ssm_raw)));

    assert_change_value_R7: assert property (@(posedge clk) disable iff (rst || !pv)
        ssm_change |-> ssm_stable != $past(ssm_stable));

    assert_stable_hold_R7: assert property (@(posedge clk) disable iff (rst || !pv)
        !ssm_change |-> $stable(ssm_stable));

    assert_change_single_R7: assert property (@(posedge clk) disable iff (rst || !pv)
        ssm_change |=> !ssm_change);
endmodule

bind e3_ssm_rx e3_ssm_rx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ma_valid     (ma_valid),
    .in_frame     (in_frame),
    .ma_byte      (ma_byte),
    .ssm_raw      (ssm_raw),
    .ssm_stable   (ssm_stable),
    .ssm_change   (ssm_change),
    .seq_err      (seq_err),
    .rdi          (rdi),
    .rei          (rei),
    .payload_type (payload_type)
);

// File: tb/tb_e3_ssm_rx.sv
module tb_e3_ssm_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ma_valid = 1'b0;
    logic       in_frame = 1'b1;
    logic [7:0] ma_byte = 8'h00;
    logic [2:0] persist_cfg = 3'd3;
    logic [3:0] ssm_raw, ssm_stable;
    logic       ssm_change, seq_err, rdi, rei;
    logic [2:0] payload_type;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    e3_ssm_rx dut (
        .clk(clk), .rst(rst), .ma_valid(ma_valid), .in_frame(in_frame),
        .ma_byte(ma_byte), .persist_cfg(persist_cfg), .ssm_raw(ssm_raw),
        .ssm_stable(ssm_stable), .ssm_change(ssm_change), .seq_err(seq_err),
        .rdi(rdi), .rei(rei), .payload_type(payload_type)
    );

    // Behavioural reference model
    int  m_raw, m_stable, m_chg, m_err, m_rdi, m_rei, m_pt;
    bit  m_hp;
    int  m_prev, m_run, m_acc, m_cand, m_cnt;
    bit  pend_done, pend_clr;
    int  pend_word;

    always @(posedge clk) begin
        if (rst) begin
            m_raw = 0; m_stable = 0; m_chg = 0; m_err = 0;
            m_rdi = 0; m_rei = 0; m_pt = 0;
            m_hp = 0; m_prev = 0; m_run = 0; m_acc = 0; m_cand = 0; m_cnt = 0;
            pend_done = 0; pend_clr = 0; pend_word = 0;
        end else begin
            bit pd, pc;
            int pw;
            pd = pend_done; pc = pend_clr; pw = pend_word;
            pend_done = 0; pend_clr = 0;
            m_chg = 0; m_err = 0;
            if (pd) begin
                int nc, th;
                if (m_cnt != 0 && pw == m_cand) nc = (m_cnt < 7) ? m_cnt + 1 : 7;
                else nc = 1;
                m_cand = pw; m_cnt = nc;
                th = (persist_cfg == 0) ? 1 : int'(persist_cfg);
                if (nc >= th && pw != m_stable) begin
                    m_stable = pw; m_chg = 1;
                end
            end else if (pc) begin
                m_cnt = 0;
            end
            if (!in_frame) begin
                m_hp = 0; m_run = 0; m_acc = 0; pend_clr = 1;
            end else if (ma_valid) begin
                int ix, b;
                bit ok;
                ix = int'(ma_byte[2:1]); b = int'(ma_byte[0]);
                ok = !m_hp || ix == ((m_prev + 1) % 4);
                if (!ok) begin m_err = 1; pend_clr = 1; end
                m_hp = 1; m_prev = ix;
                if (ix == 0) begin
                    m_run = 1; m_acc = b * 8;
                end else if (ok && m_run == ix) begin
                    m_acc = m_acc | (b << (3 - ix));
                    if (ix == 3) begin
                        m_raw = m_acc; pend_done = 1; pend_word = m_acc; m_run = 0;
                    end else m_run = ix + 1;
                end else m_run = 0;
                m_rdi = int'(ma_byte[7]); m_rei = int'(ma_byte[6]); m_pt = int'(ma_byte[5:3]);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(int'(ssm_raw) == m_raw, "R3 ssm_raw", int'(ssm_raw), m_raw);
            chk(int'(ssm_stable) == m_stable, "R6 ssm_stable", int'(ssm_stable), m_stable);
            chk(int'(ssm_change) == m_chg, "R7 ssm_change", int'(ssm_change), m_chg);
            chk(int'(seq_err) == m_err, "R4 seq_err", int'(seq_err), m_err);
            chk(int'({rdi, rei, payload_type}) == ((m_rdi << 4) | (m_rei << 3) | m_pt),
                "R1 fields", int'({rdi, rei, payload_type}), (m_rdi << 4) | (m_rei << 3) | m_pt);
        end
    end

    task automatic strobe(input int ix, input int b, input int hi, input int gap);
        @(negedge clk);
        ma_valid = 1'b1;
        ma_byte  = 8'((hi << 3) | (ix << 1) | b);
        @(negedge clk);
        ma_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_mf(input int val, input int n, input int gap);
        for (int k = 0; k < n; k++)
            for (int i = 0; i < 4; i++)
                strobe(i, (val >> (3 - i)) & 1, (val + i + k) % 32, gap);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        chk({ssm_raw, ssm_stable, ssm_change, seq_err, rdi, rei, payload_type} == '0,
            "R8 reset", int'({ssm_raw, ssm_stable}), 0);

        // R9: start mid-sequence
        strobe(2, 1, 5, 1);
        chk(seq_err == 1'b0, "R9 first strobe", int'(seq_err), 0);
        strobe(3, 1, 6, 1);
        chk(ssm_raw == 4'd0, "R9 no word", int'(ssm_raw), 0);

        // R6/R7: 0xB three times with threshold 3
        send_mf(4'hB, 2, 1);
        repeat (2) @(negedge clk);
        chk(ssm_stable == 4'd0, "R6 below threshold", int'(ssm_stable), 0);
        send_mf(4'hB, 1, 1);
        repeat (2) @(negedge clk);
        chk(ssm_stable == 4'hB, "R6 threshold met", int'(ssm_stable), 11);

        // R4/R6: run of 0x5 broken by a skipped index
        send_mf(4'h5, 2, 1);
        strobe(0, 0, 1, 1);
        strobe(2, 0, 2, 0);
        chk(seq_err == 1'b1, "R4 skip raises error", int'(seq_err), 1);
        send_mf(4'h5, 2, 1);
        repeat (2) @(negedge clk);
        chk(ssm_stable == 4'hB, "R6 run restarted", int'(ssm_stable), 11);
        send_mf(4'h5, 1, 1);
        repeat (2) @(negedge clk);
        chk(ssm_stable == 4'h5, "R6 after restart", int'(ssm_stable), 5);

        // R2: strobes while out of alignment
        in_frame = 1'b0;
        strobe(0, 1, 31, 0);
        strobe(1, 1, 31, 0);
        chk({rdi, rei, payload_type} != 5'd31, "R2 fields ignored", int'({rdi, rei, payload_type}), 0);
        chk(ssm_raw == 4'h5, "R2 raw ignored", int'(ssm_raw), 5);
        in_frame = 1'b1;

        // R5: alignment drop in the middle of a word
        strobe(0, 1, 3, 0);
        strobe(1, 1, 3, 0);
        in_frame = 1'b0;
        @(negedge clk);
        in_frame = 1'b1;
        strobe(2, 1, 4, 0);
        chk(seq_err == 1'b0, "R5 no error after flush", int'(seq_err), 0);
        strobe(3, 1, 4, 1);
        chk(ssm_raw == 4'h5, "R5 partial discarded", int'(ssm_raw), 5);

        // R6: thresholds 1, 0 and saturating 7, back-to-back strobes
        persist_cfg = 3'd1;
        send_mf(4'h3, 1, 0);
        repeat (2) @(negedge clk);
        chk(ssm_stable == 4'h3, "R6 threshold 1", int'(ssm_stable), 3);
        persist_cfg = 3'd0;
        send_mf(4'h9, 1, 0);
        repeat (2) @(negedge clk);
        chk(ssm_stable == 4'h9, "R6 threshold 0", int'(ssm_stable), 9);
        persist_cfg = 3'd7;
        send_mf(4'h6, 6, 0);
        repeat (2) @(negedge clk);
        chk(ssm_stable == 4'h9, "R6 threshold 7 pending", int'(ssm_stable), 9);
        send_mf(4'h6, 3, 0);
        repeat (2) @(negedge clk);
        chk(ssm_stable == 4'h6, "R6 threshold 7 met", int'(ssm_stable), 6);

        // R7: repeat of the validated value gives no pulse
        persist_cfg = 3'd3;
        send_mf(4'h6, 4, 1);
        send_mf(4'hA, 3, 0);
        repeat (3) @(negedge clk);
        chk(ssm_stable == 4'hA, "R7 final value", int'(ssm_stable), 10);

        // R8: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({ssm_raw, ssm_stable, rdi, rei, payload_type} == '0, "R8 reset again",
            int'({ssm_raw, ssm_stable}), 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule